// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. It moves data units from a source address to a destination address. One side of every transfer is called the peripheral side and the other the memory side, and a direction bit picks which of the two is read. Software sets the channel up with four registers: a control word, a 16-bit remaining-count register, and a base address for each side. The channel starts when the enable bit in the control word goes from 0 to 1.

Each data unit takes one read and one write, which the channel issues as simple request/acknowledge transactions on a read port and a write port. A unit starts on a peripheral request pulse, or, in memory-to-memory mode, as soon as the previous unit has finished.

The remaining count goes down by one after every unit that completes. The channel can pulse three events: half-way, done and bus error. In circular mode the count and both address pointers are reloaded when the count runs out, so the same buffer is walked again. A bus error stops the channel.

Top module: `dma_xfer_chan`

## Requirements
- R1: After reset, ctrl_o, remaining_o, both bus requests and all three event outputs are 0.
- R2: The control word has these fields, and ctrl_o returns the value last written. Bit 0 enable. Bit 1 direction (0: read the peripheral side and write the memory side; 1: the reverse). Bit 2 circular. Bit 3 peripheral increment. Bit 4 memory increment. Bits 6:5 peripheral unit size. Bits 8:7 memory unit size. Bits 10:9 priority (stored only). Bit 11 memory-to-memory. Bit 12 done-event enable. Bit 13 half-event enable. Bit 14 error-event enable.
- R3: cfg_sel selects the register that a write goes to: 0 control, 1 count, 2 peripheral base, 3 memory base. A count write is ignored while the enable bit is 1. While the enable bit is 0, a count write sets both the remaining count and the reload value.
- R4: The remaining count goes down by one after each unit that completes. In normal mode it stays at 0 once it gets there, and no further unit starts, even if more requests arrive.
- R5: In circular mode without memory-to-memory, when the last unit completes, the count is set back to the reload value and both pointers are set back to their bases, and transfers continue. With memory-to-memory set, the circular bit has no effect.
- R6: A side whose increment bit is set moves its pointer forward after each unit, by 1, 2 or 4 for size codes 0, 1 and 2 (code 3 also steps by 4). A side whose increment bit is clear keeps its pointer fixed. Both pointers are set to their bases when the channel is enabled.
- R7: The read is done at the source pointer with the source size and the write at the destination pointer with the destination size. The write data is the read data cut down to the source size and then to the destination size (byte 0xFF, halfword 0xFFFF, word all ones), with zero in all higher bits.
- R8: In peripheral mode, each periph_req pulse moves one unit; one request that arrives while a unit is in flight is held until that unit ends. In memory-to-memory mode, units run back to back. A read request stays asserted until it is acknowledged or errors, and the read and write requests are never asserted together.
- R9: evt_done pulses for one cycle when the count reaches 0. evt_half pulses for one cycle when the count falls to the reload value divided by two, rounded down; with a reload value of 1 both events fire in the same cycle. Each event only pulses if its enable bit is set.
- R10: An error response to a read or a write pulses evt_err (if enabled) and clears the enable bit. The count does not change.
- R11: If the count is 0 when the channel is enabled, no bus request is made and no event fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 control, 1 count, 2 peripheral base, 3 memory base) |
| cfg_wdata | input | 32 | Register write data |
| ctrl_o | output | 16 | Current control word |
| remaining_o | output | 16 | Remaining unit count |
| periph_req | input | 1 | Peripheral transfer request pulse |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Read address |
| rd_size | output | 2 | Read unit size code |
| rd_data | input | 32 | Read data |
| rd_ack | input | 1 | Read acknowledge |
| rd_err | input | 1 | Read error response |
| wr_req | output | 1 | Write request |
| wr_addr | output | AW | Write address |
| wr_size | output | 2 | Write unit size code |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Write acknowledge |
| wr_err | input | 1 | Write error response |
| evt_half | output | 1 | Half-way event pulse |
| evt_done | output | 1 | Done event pulse |
| evt_err | output | 1 | Bus error event pulse |

## Verification
The half-way and done events can fall in the same cycle when the count is programmed to 1, because half of 1 rounded down is 0. In circular mode, the done event and the reload of the count and pointers also happen in the same clock edge. The bench sets up a memory-to-memory run of one unit with both event enables on and counts the cycles in which both event outputs are high; exactly one such cycle is expected. For a circular peripheral run, it checks the addresses of the units that follow a wrap and the count left at the end, and the total number of done and half-way pulses is compared with a per-unit model kept in the bench.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  localparam int DW = 32;
  localparam int CW = 16;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_PBASE = 2'd2,
    SEL_MBASE = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic       te_ie;
    logic       ht_ie;
    logic       tc_ie;
    logic       m2m;
    logic [1:0] prio;
    logic [1:0] msize;
    logic [1:0] psize;
    logic       minc;
    logic       pinc;
    logic       circ;
    logic       dir;
    logic       en;
  } chan_ctrl_t;

  localparam int CTRL_W = $bits(chan_ctrl_t);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } xfer_state_e;

  // bytes covered by one unit of the given size code
  function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // lanes kept for a unit of the given size code
  function automatic logic [DW-1:0] unit_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return DW'(32'h0000_00FF);
      2'd1:    return DW'(32'h0000_FFFF);
      default: return '1;
    endcase
  endfunction

  // count value at which the half-way event fires
  function automatic logic [CW-1:0] half_mark(input logic [CW-1:0] reload);
    return reload >> 1;
  endfunction

endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_xfer_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          step,
  input  logic          inc,
  input  logic [1:0]    size,
  output logic [AW-1:0] ptr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= base;
    end else if (step && inc) begin
      ptr <= ptr + AW'(unit_bytes(size));
    end
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_xfer_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          unit_done,
  input  logic          bus_err,
  output chan_ctrl_t    ctrl,
  output logic [AW-1:0] pbase,
  output logic [AW-1:0] mbase,
  output logic [CW-1:0] remaining,
  output logic [CW-1:0] reload,
  output logic          start,
  output logic          count_wr_try,
  output logic          last_unit,
  output logic          wrap_now,
  output logic          half_hit
);

  logic ctrl_wr;
  logic count_wr;

  assign ctrl_wr      = cfg_we && (cfg_sel == SEL_CTRL);
  assign count_wr_try = cfg_we && (cfg_sel == SEL_COUNT);
  assign count_wr     = count_wr_try && !ctrl.en;
  assign start        = ctrl_wr && cfg_wdata[0] && !ctrl.en;

  assign last_unit = unit_done && (remaining == CW'(1));
  assign wrap_now  = last_unit && ctrl.circ && !ctrl.m2m;
  assign half_hit  = unit_done && ((remaining - CW'(1)) == half_mark(reload));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (ctrl_wr) ctrl <= chan_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
      if (bus_err) ctrl.en <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pbase <= '0;
      mbase <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == SEL_PBASE) pbase <= cfg_wdata[AW-1:0];
      if (cfg_sel == SEL_MBASE) mbase <= cfg_wdata[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining <= '0;
      reload    <= '0;
    end else if (count_wr) begin
      remaining <= cfg_wdata[CW-1:0];
      reload    <= cfg_wdata[CW-1:0];
    end else if (unit_done) begin
      if (remaining == CW'(1)) remaining <= wrap_now ? reload : '0;
      else if (remaining != '0) remaining <= remaining - CW'(1);
    end
  end

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_xfer_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          m2m,
  input  logic          preq,
  input  logic          cnt_nz,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [1:0]    src_size,
  input  logic [1:0]    dst_size,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic [1:0]    rd_size,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_ack,
  input  logic          rd_err,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [1:0]    wr_size,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ack,
  input  logic          wr_err,
  output logic          unit_done,
  output logic          bus_err,
  output logic          busy
);

  xfer_state_e   st;
  logic          pend;
  logic          launch;
  logic [DW-1:0] data_q;

  assign launch = (st == ST_IDLE) && en && cnt_nz && (m2m || pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      data_q <= '0;
    end else begin
      case (st)
        ST_IDLE:  if (launch) st <= ST_READ;
        ST_READ: begin
          if (rd_err) begin
            st <= ST_IDLE;
          end else if (rd_ack) begin
            data_q <= rd_data & unit_mask(src_size);
            st     <= ST_WRITE;
          end
        end
        ST_WRITE: if (wr_ack || wr_err) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  // one-deep hold of a peripheral request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (!en || m2m) begin
      pend <= 1'b0;
    end else begin
      if (launch) pend <= 1'b0;
      if (preq)   pend <= 1'b1;
    end
  end

  assign rd_req    = (st == ST_READ);
  assign wr_req    = (st == ST_WRITE);
  assign rd_addr   = src_addr;
  assign rd_size   = src_size;
  assign wr_addr   = dst_addr;
  assign wr_size   = dst_size;
  assign wr_data   = data_q & unit_mask(dst_size);
  assign unit_done = (st == ST_WRITE) && wr_ack && !wr_err;
  assign bus_err   = ((st == ST_READ) && rd_err) || ((st == ST_WRITE) && wr_err);
  assign busy      = (st != ST_IDLE);

endmodule

// File: rtl/dma_xfer_chan.sv
module dma_xfer_chan
  import dma_xfer_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic [15:0]   ctrl_o,
  output logic [15:0]   remaining_o,
  input  logic          periph_req,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic [1:0]    rd_size,
  input  logic [31:0]   rd_data,
  input  logic          rd_ack,
  input  logic          rd_err,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [1:0]    wr_size,
  output logic [31:0]   wr_data,
  input  logic          wr_ack,
  input  logic          wr_err,
  output logic          evt_half,
  output logic          evt_done,
  output logic          evt_err
);

  localparam int NSIDE = 2;
  localparam int PSIDE = 0;
  localparam int MSIDE = 1;

  chan_ctrl_t    ctrl_q;
  logic [AW-1:0] pbase_q, mbase_q;
  logic [CW-1:0] remaining_q, reload_q;
  logic          start, count_wr_try, last_unit, wrap_now, half_hit;
  logic          unit_done, bus_err, xfer_busy, chan_en, ptr_load;

  logic [AW-1:0] side_base [NSIDE];
  logic [AW-1:0] side_ptr  [NSIDE];
  logic          side_inc  [NSIDE];
  logic [1:0]    side_size [NSIDE];

  logic [AW-1:0] src_addr, dst_addr;
  logic [1:0]    src_size, dst_size;

  dma_chan_regs #(.AW(AW)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_sel      (cfg_sel),
    .cfg_wdata    (cfg_wdata),
    .unit_done    (unit_done),
    .bus_err      (bus_err),
    .ctrl         (ctrl_q),
    .pbase        (pbase_q),
    .mbase        (mbase_q),
    .remaining    (remaining_q),
    .reload       (reload_q),
    .start        (start),
    .count_wr_try (count_wr_try),
    .last_unit    (last_unit),
    .wrap_now     (wrap_now),
    .half_hit     (half_hit)
  );

  assign chan_en  = ctrl_q.en;
  assign ptr_load = start || wrap_now;

  always_comb begin
    side_base[PSIDE] = pbase_q;
    side_base[MSIDE] = mbase_q;
    side_inc[PSIDE]  = ctrl_q.pinc;
    side_inc[MSIDE]  = ctrl_q.minc;
    side_size[PSIDE] = ctrl_q.psize;
    side_size[MSIDE] = ctrl_q.msize;
  end

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma_addr_gen #(.AW(AW)) u_ag (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ptr_load),
      .base  (side_base[g]),
      .step  (unit_done),
      .inc   (side_inc[g]),
      .size  (side_size[g]),
      .ptr   (side_ptr[g])
    );
  end

  // direction picks which side is read
  always_comb begin
    if (ctrl_q.dir) begin
      src_addr = side_ptr[MSIDE];  src_size = side_size[MSIDE];
      dst_addr = side_ptr[PSIDE];  dst_size = side_size[PSIDE];
    end else begin
      src_addr = side_ptr[PSIDE];  src_size = side_size[PSIDE];
      dst_addr = side_ptr[MSIDE];  dst_size = side_size[MSIDE];
    end
  end

  dma_xfer_fsm #(.AW(AW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (chan_en),
    .m2m       (ctrl_q.m2m),
    .preq      (periph_req),
    .cnt_nz    (remaining_q != '0),
    .src_addr  (src_addr),
    .dst_addr  (dst_addr),
    .src_size  (src_size),
    .dst_size  (dst_size),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_size   (rd_size),
    .rd_data   (rd_data),
    .rd_ack    (rd_ack),
    .rd_err    (rd_err),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_size   (wr_size),
    .wr_data   (wr_data),
    .wr_ack    (wr_ack),
    .wr_err    (wr_err),
    .unit_done (unit_done),
    .bus_err   (bus_err),
    .busy      (xfer_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_half <= 1'b0;
      evt_done <= 1'b0;
      evt_err  <= 1'b0;
    end else begin
      evt_half <= half_hit  && ctrl_q.ht_ie;
      evt_done <= last_unit && ctrl_q.tc_ie;
      evt_err  <= bus_err   && ctrl_q.te_ie;
    end
  end

  assign ctrl_o      = 16'(ctrl_q);
  assign remaining_o = remaining_q;

endmodule

// File: rtl/dma_xfer_chan_chk.sv
module dma_xfer_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        busy,
  input logic        count_wr_try,
  input logic [15:0] remaining,
  input logic [15:0] reload,
  input logic        last_unit,
  input logic        bus_err,
  input logic        rd_req,
  input logic        wr_req,
  input logic        rd_ack,
  input logic        rd_err
);

  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !busy && !count_wr_try) |=> $stable(remaining));

  // R4
  done_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_unit |=> (remaining == 16'd0 || remaining == $past(reload)));

  // R10
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> !en);

  // R8
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req, wr_req}));

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack && !rd_err) |=> rd_req);

  // R11
  zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && remaining == 16'd0 && !busy) |=> !rd_req);

endmodule

bind dma_xfer_chan dma_xfer_chan_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en           (chan_en),
  .busy         (xfer_busy),
  .count_wr_try (count_wr_try),
  .remaining    (remaining_q),
  .reload       (reload_q),
  .last_unit    (last_unit),
  .bus_err      (bus_err),
  .rd_req       (rd_req),
  .wr_req       (wr_req),
  .rd_ack       (rd_ack),
  .rd_err       (rd_err)
);

// File: tb/sim_dma_xfer_chan.sv
`timescale 1ns/1ps
module sim_dma_xfer_chan;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [15:0] ctrl_o, remaining_o;
  logic        periph_req = 1'b0;
  logic        rd_req, wr_req;
  logic [31:0] rd_addr, wr_addr, wr_data;
  logic [1:0]  rd_size, wr_size;
  logic [31:0] rd_data = 32'd0;
  logic        rd_ack = 1'b0, rd_err = 1'b0, wr_ack = 1'b0, wr_err = 1'b0;
  logic        evt_half, evt_done, evt_err;

  always #2.5 clk = ~clk;

  dma_xfer_chan u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ctrl_o(ctrl_o), .remaining_o(remaining_o), .periph_req(periph_req),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size), .rd_data(rd_data),
    .rd_ack(rd_ack), .rd_err(rd_err), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_size(wr_size), .wr_data(wr_data), .wr_ack(wr_ack), .wr_err(wr_err),
    .evt_half(evt_half), .evt_done(evt_done), .evt_err(evt_err)
  );

  int errors = 0, checks = 0;
  int nwr = 0, tc_cnt = 0, ht_cnt = 0, both_cnt = 0, te_cnt = 0, rd_cnt = 0;
  bit inj_rd_err = 1'b0;

  // expected configuration of the current run
  bit        e_dir, e_circ, e_pinc, e_minc, e_ie;
  logic [1:0]  e_psz, e_msz;
  logic [31:0] e_pbase, e_mbase;
  int        e_n;

  function automatic logic [31:0] mem_f(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] sz_bytes(input logic [1:0] s);
    return (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : 32'd4;
  endfunction

  function automatic logic [31:0] sz_mask(input logic [1:0] s);
    return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] mk_ctrl(input bit en, input bit dir, input bit circ,
      input bit pinc, input bit minc, input logic [1:0] psz, input logic [1:0] msz,
      input logic [1:0] prio, input bit m2m, input logic [2:0] ie);
    return {17'd0, ie[2], ie[1], ie[0], m2m, prio, msz, psz, minc, pinc, circ, dir, en};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-unit write check against the bench model
  task automatic log_write();
    int j;
    logic [31:0] sb, db, sa, da, ed;
    logic [1:0]  ssz, dsz;
    bit sinc, dinc;
    j = e_circ ? (nwr % e_n) : nwr;
    if (!e_dir) begin
      sb = e_pbase; sinc = e_pinc; ssz = e_psz; db = e_mbase; dinc = e_minc; dsz = e_msz;
    end else begin
      sb = e_mbase; sinc = e_minc; ssz = e_msz; db = e_pbase; dinc = e_pinc; dsz = e_psz;
    end
    sa = sb + (sinc ? 32'(j) * sz_bytes(ssz) : 32'd0);
    da = db + (dinc ? 32'(j) * sz_bytes(dsz) : 32'd0);
    ed = mem_f(sa) & sz_mask(ssz) & sz_mask(dsz);
    chk(wr_addr == da, "R6", "write address", wr_addr, da);
    chk(wr_data == ed, "R7", "write data", wr_data, ed);
    chk(wr_size == dsz, "R7", "write size", {30'd0, wr_size}, {30'd0, dsz});
    nwr++;
  endtask

  // bus responder with random latency
  initial forever begin
    @(negedge clk);
    rd_ack = 1'b0; rd_err = 1'b0; wr_ack = 1'b0; wr_err = 1'b0;
    if (rst_n) begin
      if (rd_req) begin
        if (inj_rd_err) begin
          rd_err = 1'b1; inj_rd_err = 1'b0;
        end else if ($urandom % 3 != 0) begin
          rd_ack = 1'b1; rd_data = mem_f(rd_addr);
        end
      end
      if (wr_req && ($urandom % 3 != 0)) begin
        wr_ack = 1'b1;
        log_write();
      end
    end
  end

  // event monitor
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (evt_done) tc_cnt++;
      if (evt_half) ht_cnt++;
      if (evt_done && evt_half) both_cnt++;
      if (evt_err) te_cnt++;
      if (rd_req) rd_cnt++;
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); periph_req = 1'b1;
    @(negedge clk); periph_req = 1'b0;
  endtask

  task automatic wait_units(input int target);
    int t = 0;
    while (nwr < target && t < 3000) begin @(negedge clk); t++; end
    repeat (6) @(negedge clk);
  endtask

  task automatic clear_counts();
    nwr = 0; tc_cnt = 0; ht_cnt = 0; both_cnt = 0; te_cnt = 0; rd_cnt = 0;
  endtask

  task automatic setup(input bit dir, input bit circ, input bit pinc, input bit minc,
      input logic [1:0] psz, input logic [1:0] msz, input bit m2m, input logic [2:0] ie,
      input int n, input logic [31:0] pb, input logic [31:0] mb);
    e_dir = dir; e_circ = circ && !m2m; e_pinc = pinc; e_minc = minc;
    e_psz = psz; e_msz = msz; e_n = n; e_pbase = pb; e_mbase = mb; e_ie = (ie == 3'b111);
    cfg_write(2'd0, mk_ctrl(0, dir, circ, pinc, minc, psz, msz, 2'd1, m2m, ie));
    cfg_write(2'd1, 32'(n));
    cfg_write(2'd2, pb);
    cfg_write(2'd3, mb);
    clear_counts();
    cfg_write(2'd0, mk_ctrl(1, dir, circ, pinc, minc, psz, msz, 2'd1, m2m, ie));
  endtask

  // compare totals after K completed units
  task automatic finish_run(input int k, input string tag);
    int tc_e = 0, ht_e = 0, rem_e;
    for (int u = 0; u < k; u++) begin
      int j = e_circ ? (u % e_n) : u;
      if (j == e_n - 1) tc_e++;
      if (e_n - 1 - j == e_n / 2) ht_e++;
    end
    if (!e_ie) begin tc_e = 0; ht_e = 0; end
    if (e_circ) rem_e = (k % e_n == 0) ? e_n : e_n - (k % e_n);
    else        rem_e = e_n - k;
    chk(nwr == k, "R8", {tag, " unit count"}, 32'(nwr), 32'(k));
    chk(tc_cnt == tc_e, "R9", {tag, " done pulses"}, 32'(tc_cnt), 32'(tc_e));
    chk(ht_cnt == ht_e, "R9", {tag, " half pulses"}, 32'(ht_cnt), 32'(ht_e));
    chk(remaining_o == 16'(rem_e), e_circ ? "R5" : "R4", {tag, " remaining"},
        {16'd0, remaining_o}, 32'(rem_e));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(ctrl_o == 16'd0, "R1", "ctrl after reset", {16'd0, ctrl_o}, 32'd0);
    chk(remaining_o == 16'd0, "R1", "count after reset", {16'd0, remaining_o}, 32'd0);
    chk(!rd_req && !wr_req, "R1", "requests after reset", {30'd0, rd_req, wr_req}, 32'd0);
    chk(!evt_done && !evt_half && !evt_err, "R1", "events after reset",
        {29'd0, evt_done, evt_half, evt_err}, 32'd0);

    // R2 control readback with fields at their positions
    begin
      logic [31:0] v = mk_ctrl(0, 1, 1, 0, 1, 2'd2, 2'd1, 2'd2, 0, 3'b101);
      cfg_write(2'd0, v);
      @(negedge clk);
      chk(ctrl_o == v[15:0], "R2", "control readback", {16'd0, ctrl_o}, v);
    end

    // R9 count of 1: half and done in the same cycle
    setup(0, 0, 1, 1, 2'd2, 2'd2, 1, 3'b111, 1, 32'h100, 32'h200);
    wait_units(1);
    finish_run(1, "single");
    chk(both_cnt == 1, "R9", "half and done together", 32'(both_cnt), 32'd1);

    // R11 zero count does nothing
    setup(0, 0, 1, 1, 2'd0, 2'd0, 1, 3'b111, 0, 32'h300, 32'h400);
    repeat (20) @(negedge clk);
    chk(rd_cnt == 0, "R11", "reads with zero count", 32'(rd_cnt), 32'd0);
    chk(tc_cnt + ht_cnt == 0, "R11", "events with zero count", 32'(tc_cnt + ht_cnt), 32'd0);

    // R3 count write ignored while enabled, accepted while disabled
    setup(1, 0, 1, 0, 2'd1, 2'd0, 0, 3'b111, 5, 32'h500, 32'h600);
    cfg_write(2'd1, 32'd2);
    @(negedge clk);
    chk(remaining_o == 16'd5, "R3", "count write while enabled", {16'd0, remaining_o}, 32'd5);
    for (int i = 0; i < 7; i++) begin
      pulse_req();
      wait_units((i + 1 < 5) ? i + 1 : 5);
    end
    finish_run(5, "R4 normal stop");
    chk(ctrl_o[0] == 1'b1, "R4", "enable kept at end", {31'd0, ctrl_o[0]}, 32'd1);
    cfg_write(2'd0, mk_ctrl(0, 1, 0, 1, 0, 2'd1, 2'd0, 2'd1, 0, 3'b111));
    cfg_write(2'd1, 32'd2);
    @(negedge clk);
    chk(remaining_o == 16'd2, "R3", "count write while disabled", {16'd0, remaining_o}, 32'd2);
    clear_counts(); e_n = 2;
    cfg_write(2'd0, mk_ctrl(1, 1, 0, 1, 0, 2'd1, 2'd0, 2'd1, 0, 3'b111));
    for (int i = 0; i < 2; i++) begin pulse_req(); wait_units(i + 1); end
    finish_run(2, "R3 restart");

    // R5 circular peripheral run wraps pointers and count
    setup(0, 1, 1, 1, 2'd0, 2'd1, 0, 3'b111, 3, 32'h1000, 32'h2000);
    for (int i = 0; i < 7; i++) begin pulse_req(); wait_units(i + 1); end
    finish_run(7, "R5 circular");

    // R5 circular bit ignored in memory-to-memory mode
    setup(1, 1, 1, 1, 2'd2, 2'd0, 1, 3'b111, 3, 32'h3000, 32'h4000);
    wait_units(3);
    repeat (20) @(negedge clk);
    finish_run(3, "R5 m2m circ");

    // R9 events masked by their enable bits
    setup(0, 0, 1, 1, 2'd1, 2'd1, 1, 3'b000, 4, 32'h5000, 32'h6000);
    wait_units(4);
    finish_run(4, "R9 masked");

    // R10 read error stops the channel
    setup(0, 0, 1, 1, 2'd0, 2'd0, 0, 3'b111, 4, 32'h7000, 32'h8000);
    inj_rd_err = 1'b1;
    pulse_req();
    repeat (10) @(negedge clk);
    chk(te_cnt == 1, "R10", "error pulses", 32'(te_cnt), 32'd1);
    chk(ctrl_o[0] == 1'b0, "R10", "enable after error", {31'd0, ctrl_o[0]}, 32'd0);
    chk(remaining_o == 16'd4, "R10", "count after error", {16'd0, remaining_o}, 32'd4);
    pulse_req();
    repeat (10) @(negedge clk);
    chk(nwr == 0, "R10", "units after error", 32'(nwr), 32'd0);

    // random runs, R6 R7 R8 over mixed sizes and modes
    for (int r = 0; r < 12; r++) begin
      bit m2m = 1'($urandom % 2);
      bit circ = 1'($urandom % 2);
      int n = 1 + int'($urandom % 9);
      int units;
      setup(1'($urandom % 2), circ, 1'($urandom % 2), 1'($urandom % 2),
            2'($urandom % 4), 2'($urandom % 4), m2m, 3'b111, n,
            $urandom & 32'hFFFF_FFF0, $urandom & 32'hFFFF_FFF0);
      if (m2m) begin
        units = n;
        wait_units(n);
        repeat (10) @(negedge clk);
      end else begin
        int reqs = circ ? n + 1 + int'($urandom % n) : n + 2;
        units = circ ? reqs : n;
        for (int i = 0; i < reqs; i++) begin
          pulse_req();
          wait_units((i + 1 < units) ? i + 1 : units);
        end
      end
      finish_run(units, "random");
      cfg_write(2'd0, 32'd0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule